// File: doc/BRIEF.md
# Counted Loop Branch Resolver

This unit resolves one counted-loop branch step. A core hands it the 4-bit test selector, the four arithmetic flags, the loop-counter register, the address of the displacement word and the 16-bit signed displacement, all qualified by a one-cycle `go_i` strobe. One clock later the unit presents the updated counter, a write enable for the register file, a taken indication and the next program address, marked by a one-cycle `done_o`.

The test sense is the reverse of an ordinary conditional branch. A satisfied test ends the loop at once and leaves the counter alone. An unsatisfied test decrements the low half of the counter. The unit then branches back, unless the decremented low half is exactly all ones (minus one), in which case it falls through. Selector 1 never succeeds, so it gives a plain counted loop. Selector 0 always succeeds, so it never branches.

Top module: `dbl_loop_ctrl`

## Requirements
- R1: While reset is held and after its release, `done_o`, `taken_o` and `count_we_o` read 0 and `count_o` and `next_pc_o` read zero until the first accepted request.
- R2: A request sampled with `go_i`=1 on a rising edge is reflected on all outputs after that edge, with `done_o`=1 for exactly that one cycle. In a cycle after `go_i`=0 is sampled, `done_o` is 0 and `count_o`, `count_we_o`, `taken_o` and `next_pc_o` keep their values.
- R3: When the selected test is satisfied, `count_we_o`=0, `taken_o`=0, `count_o` equals `count_i` and `next_pc_o` = `pc_i`+2.
- R4: When the selected test is not satisfied, `count_we_o`=1, bits 15:0 of `count_o` equal bits 15:0 of `count_i` minus one (modulo 2^16), and bits 31:16 equal those of `count_i`.
- R5: When the test is not satisfied and the decremented low half is not 16'hFFFF, `taken_o`=1 and `next_pc_o` = `pc_i` + the sign-extended `disp_i`. When it is 16'hFFFF, `taken_o`=0 and `next_pc_o` = `pc_i`+2.
- R6: The loop end is detected only by equality with 16'hFFFF, not by sign. A low half of 16'h8000 steps to 16'h7FFF and is taken, 16'hFFFF steps to 16'hFFFE and is taken, and 16'h0000 steps to 16'hFFFF and falls through.
- R7: `flags_i` is {N,Z,V,C} with N in bit 3 and C in bit 0. The selector `cond_i` means: 0 always, 1 never, 2 !C&!Z, 3 C|Z, 4 !C, 5 C, 6 !Z, 7 Z, 8 !V, 9 V, 10 !N, 11 N, 12 N==V, 13 N!=V, 14 !Z&(N==V), 15 Z|(N!=V).
- R8: Selector 0 never writes the counter and never branches. Selector 1 always writes the counter, for any flags.
- R9: With selector 1 and a starting low half of 15, feeding `count_o` back gives 16 steps. The first 15 are taken and the 16th falls through with the low half at 16'hFFFF.
- R10: `taken_o`=1 is only ever reported together with `count_we_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Request strobe qualifying the other inputs |
| cond_i | input | 4 | Loop test selector |
| flags_i | input | 4 | Flags {N,Z,V,C} |
| count_i | input | 32 | Loop-counter register value |
| pc_i | input | 32 | Address of the displacement word |
| disp_i | input | 16 | Signed branch displacement |
| done_o | output | 1 | Result valid, one cycle per request |
| count_o | output | 32 | Updated counter value |
| count_we_o | output | 1 | Counter write enable |
| taken_o | output | 1 | Branch back to the loop label |
| next_pc_o | output | 32 | Next program address |

## Verification
The bound checker checks on every cycle the one-cycle request-to-done timing and the holding of outputs when idle. It also checks that the counter upper half is preserved, that the low half steps down by exactly one whenever a write is reported, that taken agrees with the all-ones exit test, that fall-through goes to the word after the displacement, and that selector 0 is inert. Only the bench scenarios can show that all sixteen selectors decode correctly across every flag combination, that branch targets are right for forward and backward displacements, and that a full counted loop from 15 runs exactly 16 steps.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  typedef enum logic [3:0] {
    SEL_ALWAYS = 4'd0,
    SEL_NEVER  = 4'd1,
    SEL_HI     = 4'd2,
    SEL_LS     = 4'd3,
    SEL_CCLR   = 4'd4,
    SEL_CSET   = 4'd5,
    SEL_NE     = 4'd6,
    SEL_EQ     = 4'd7,
    SEL_VCLR   = 4'd8,
    SEL_VSET   = 4'd9,
    SEL_PL     = 4'd10,
    SEL_MI     = 4'd11,
    SEL_GE     = 4'd12,
    SEL_LT     = 4'd13,
    SEL_GT     = 4'd14,
    SEL_LE     = 4'd15
  } loop_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/dbl_cond_eval.sv
module dbl_cond_eval
  import dbl_pkg::*;
(
  input  logic [3:0] sel_i,
  input  alu_flags_t flg_i,
  output logic       met_o
);

  logic signed_ge;

  assign signed_ge = (flg_i.n == flg_i.v);

  always_comb begin
    unique case (loop_sel_e'(sel_i))
      SEL_ALWAYS: met_o = 1'b1;
      SEL_NEVER:  met_o = 1'b0;
      SEL_HI:     met_o = ~flg_i.c & ~flg_i.z;
      SEL_LS:     met_o = flg_i.c | flg_i.z;
      SEL_CCLR:   met_o = ~flg_i.c;
      SEL_CSET:   met_o = flg_i.c;
      SEL_NE:     met_o = ~flg_i.z;
      SEL_EQ:     met_o = flg_i.z;
      SEL_VCLR:   met_o = ~flg_i.v;
      SEL_VSET:   met_o = flg_i.v;
      SEL_PL:     met_o = ~flg_i.n;
      SEL_MI:     met_o = flg_i.n;
      SEL_GE:     met_o = signed_ge;
      SEL_LT:     met_o = ~signed_ge;
      SEL_GT:     met_o = ~flg_i.z & signed_ge;
      SEL_LE:     met_o = flg_i.z | ~signed_ge;
      default:    met_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbl_count_step.sv
module dbl_count_step #(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cnt_dec_o,
  output logic             expired_o
);

  localparam int HI_W = CNT_W - LOOP_W;

  logic [LOOP_W-1:0] low_dec;

  assign low_dec   = cnt_i[LOOP_W-1:0] - LOOP_W'(1);
  assign expired_o = (low_dec == {LOOP_W{1'b1}});

  generate
    if (HI_W > 0) begin : g_split
      assign cnt_dec_o = {cnt_i[CNT_W-1:LOOP_W], low_dec};
    end else begin : g_full
      assign cnt_dec_o = low_dec;
    end
  endgenerate

endmodule

// File: rtl/dbl_target_gen.sv
module dbl_target_gen #(
  parameter int PC_W       = 32,
  parameter int DISP_W     = 16,
  parameter int STEP_BYTES = 2
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [PC_W-1:0]   target_o,
  output logic [PC_W-1:0]   fall_o
);

  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_noext
      assign disp_ext = disp_i[PC_W-1:0];
    end
  endgenerate

  assign target_o = pc_i + disp_ext;
  assign fall_o   = pc_i + PC_W'(STEP_BYTES);

endmodule

// File: rtl/dbl_loop_ctrl.sv
module dbl_loop_ctrl
  import dbl_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int LOOP_W     = 16,
  parameter int PC_W       = 32,
  parameter int DISP_W     = 16,
  parameter int STEP_BYTES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              count_we_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o
);

  // reset: asserted asynchronously, released through a short synchronizer
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[SYNC_STAGES-1];

  // datapath pieces
  alu_flags_t        flg;
  logic              met;
  logic [CNT_W-1:0]  cnt_dec;
  logic              expired;
  logic [PC_W-1:0]   tgt_pc;
  logic [PC_W-1:0]   fall_pc;

  assign flg = alu_flags_t'(flags_i);

  dbl_cond_eval u_cond (
    .sel_i (cond_i),
    .flg_i (flg),
    .met_o (met)
  );

  dbl_count_step #(.CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_step (
    .cnt_i     (count_i),
    .cnt_dec_o (cnt_dec),
    .expired_o (expired)
  );

  dbl_target_gen #(.PC_W(PC_W), .DISP_W(DISP_W), .STEP_BYTES(STEP_BYTES)) u_tgt (
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .target_o (tgt_pc),
    .fall_o   (fall_pc)
  );

  // next-state
  logic [CNT_W-1:0] cnt_d,  cnt_q;
  logic [PC_W-1:0]  pc_d,   pc_q;
  logic             we_d,   we_q;
  logic             tk_d,   tk_q;
  logic             done_q;

  always_comb begin
    cnt_d = count_i;
    pc_d  = fall_pc;
    we_d  = 1'b0;
    tk_d  = 1'b0;
    if (!met) begin
      cnt_d = cnt_dec;
      we_d  = 1'b1;
      if (!expired) begin
        tk_d = 1'b1;
        pc_d = tgt_pc;
      end
    end
  end

  // registers, result bank enabled by the request strobe
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= go_i;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cnt_q <= '0;
      pc_q  <= '0;
      we_q  <= 1'b0;
      tk_q  <= 1'b0;
    end else if (go_i) begin
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
      we_q  <= we_d;
      tk_q  <= tk_d;
    end
  end

  assign done_o     = done_q;
  assign count_o    = cnt_q;
  assign count_we_o = we_q;
  assign taken_o    = tk_q;
  assign next_pc_o  = pc_q;

endmodule

// File: rtl/dbl_loop_ctrl_chk.sv
module dbl_loop_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        go_i,
  input logic [3:0]  cond_i,
  input logic [31:0] count_i,
  input logic [31:0] pc_i,
  input logic        done_o,
  input logic [31:0] count_o,
  input logic        count_we_o,
  input logic        taken_o,
  input logic [31:0] next_pc_o
);

  // R2: one-cycle response to a request
  a_r2_done_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> done_o);

  // R2: idle cycles keep everything
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> (!done_o && $stable(count_o) && $stable(next_pc_o)
               && $stable(taken_o) && $stable(count_we_o)));

  // R4: upper half of the counter never changes
  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (count_o[31:16] == $past(count_i[31:16])));

  // R4: a reported write is exactly one below the old low half
  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (!count_we_o || (16'(count_o[15:0] + 16'd1) == $past(count_i[15:0]))));

  // R6: taken agrees with the all-ones exit test
  a_r6_exit_equality: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (!count_we_o || (taken_o == (count_o[15:0] != 16'hFFFF))));

  // R5: fall-through lands on the word after the displacement
  a_r5_fall_address: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (taken_o || (next_pc_o == 32'($past(pc_i) + 32'd2))));

  // R8: selector 0 is inert
  a_r8_always_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && cond_i == 4'd0) |=> (!count_we_o && !taken_o && count_o == $past(count_i)));

  // R8: selector 1 always writes
  a_r8_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && cond_i == 4'd1) |=> count_we_o);

  // R10: a branch implies a counter write
  a_r10_taken_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> count_we_o);

endmodule

bind dbl_loop_ctrl dbl_loop_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .go_i       (go_i),
  .cond_i     (cond_i),
  .count_i    (count_i),
  .pc_i       (pc_i),
  .done_o     (done_o),
  .count_o    (count_o),
  .count_we_o (count_we_o),
  .taken_o    (taken_o),
  .next_pc_o  (next_pc_o)
);

// File: tb/sim_dbl_loop_ctrl.sv
module sim_dbl_loop_ctrl;

  logic        clk;
  logic        rst_n;
  logic        go_i;
  logic [3:0]  cond_i;
  logic [3:0]  flags_i;
  logic [31:0] count_i;
  logic [31:0] pc_i;
  logic [15:0] disp_i;
  logic        done_o;
  logic [31:0] count_o;
  logic        count_we_o;
  logic        taken_o;
  logic [31:0] next_pc_o;

  int n_chk = 0;
  int n_bad = 0;

  dbl_loop_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .cond_i(cond_i), .flags_i(flags_i),
    .count_i(count_i), .pc_i(pc_i), .disp_i(disp_i), .done_o(done_o),
    .count_o(count_o), .count_we_o(count_we_o), .taken_o(taken_o),
    .next_pc_o(next_pc_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference test evaluation from the selector table, flags {N,Z,V,C}
  function automatic logic ref_met(input logic [3:0] s, input logic [3:0] f);
    logic n, z, v, c, base;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (s[3:1])
      3'd0: base = 1'b1;
      3'd1: base = !(c || z);
      3'd2: base = !c;
      3'd3: base = !z;
      3'd4: base = !v;
      3'd5: base = !n;
      3'd6: base = !(n ^ v);
      default: base = !z && !(n ^ v);
    endcase
    return s[0] ? !base : base;
  endfunction

  task automatic apply(input logic [3:0] s, input logic [3:0] f, input logic [31:0] cnt,
                       input logic [31:0] pc, input logic [15:0] d);
    @(negedge clk);
    go_i = 1'b1; cond_i = s; flags_i = f; count_i = cnt; pc_i = pc; disp_i = d;
    @(negedge clk);
    go_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 done", {63'd0, done_o}, 64'd0);
    chk("R1 taken", {63'd0, taken_o}, 64'd0);
    chk("R1 we", {63'd0, count_we_o}, 64'd0);
    chk("R1 count", {32'd0, count_o}, 64'd0);
    chk("R1 pc", {32'd0, next_pc_o}, 64'd0);
  endtask

  task automatic t_true_falls();
    apply(4'd0, 4'b0000, 32'hDEAD_0007, 32'h0000_4000, 16'hFFF0);
    chk("R2 done", {63'd0, done_o}, 64'd1);
    chk("R8 R3 we", {63'd0, count_we_o}, 64'd0);
    chk("R3 taken", {63'd0, taken_o}, 64'd0);
    chk("R3 count", {32'd0, count_o}, {32'd0, 32'hDEAD_0007});
    chk("R3 pc", {32'd0, next_pc_o}, {32'd0, 32'h0000_4002});
    apply(4'd7, 4'b0100, 32'h0000_0003, 32'h0000_1000, 16'h0010);
    chk("R3 eq met we", {63'd0, count_we_o}, 64'd0);
    chk("R3 eq met pc", {32'd0, next_pc_o}, {32'd0, 32'h0000_1002});
  endtask

  task automatic t_false_branch();
    apply(4'd1, 4'b1111, 32'h1234_0005, 32'h0000_4010, 16'hFFF8);
    chk("R4 count", {32'd0, count_o}, {32'd0, 32'h1234_0004});
    chk("R4 we", {63'd0, count_we_o}, 64'd1);
    chk("R5 taken", {63'd0, taken_o}, 64'd1);
    chk("R5 back target", {32'd0, next_pc_o}, {32'd0, 32'h0000_4008});
    apply(4'd6, 4'b0100, 32'h0000_0100, 32'h0000_2000, 16'h0040);
    chk("R5 fwd target", {32'd0, next_pc_o}, {32'd0, 32'h0000_2040});
  endtask

  task automatic t_exit();
    apply(4'd1, 4'b0000, 32'hABCD_0000, 32'h0000_5000, 16'hFF00);
    chk("R6 wrap count", {32'd0, count_o}, {32'd0, 32'hABCD_FFFF});
    chk("R6 wrap falls", {63'd0, taken_o}, 64'd0);
    chk("R5 exit pc", {32'd0, next_pc_o}, {32'd0, 32'h0000_5002});
    apply(4'd1, 4'b0000, 32'h0000_8000, 32'h0000_5000, 16'hFF00);
    chk("R6 8000 count", {32'd0, count_o}, {32'd0, 32'h0000_7FFF});
    chk("R6 8000 taken", {63'd0, taken_o}, 64'd1);
    apply(4'd1, 4'b0000, 32'h0000_FFFF, 32'h0000_5000, 16'hFF00);
    chk("R6 FFFF count", {32'd0, count_o}, {32'd0, 32'h0000_FFFE});
    chk("R6 FFFF taken", {63'd0, taken_o}, 64'd1);
  endtask

  task automatic t_hold();
    apply(4'd1, 4'b0000, 32'h0000_0009, 32'h0000_0100, 16'h0020);
    @(negedge clk);
    cond_i = 4'd0; count_i = 32'h5555_5555; pc_i = 32'h7777_0000;
    @(negedge clk);
    chk("R2 idle done", {63'd0, done_o}, 64'd0);
    chk("R2 idle count", {32'd0, count_o}, {32'd0, 32'h0000_0008});
    chk("R2 idle pc", {32'd0, next_pc_o}, {32'd0, 32'h0000_0120});
    chk("R2 idle taken", {63'd0, taken_o}, 64'd1);
  endtask

  task automatic t_table();
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 16; f++) begin
        logic m;
        m = ref_met(4'(s), 4'(f));
        apply(4'(s), 4'(f), 32'h0000_0002, 32'h0000_3000, 16'h0100);
        chk($sformatf("R7 sel %0d flags %0d we", s, f), {63'd0, count_we_o}, {63'd0, !m});
        chk($sformatf("R7 sel %0d flags %0d taken", s, f), {63'd0, taken_o}, {63'd0, !m});
        chk("R10 taken implies we", {63'd0, taken_o && !count_we_o}, 64'd0);
      end
    end
  endtask

  task automatic t_loop15();
    logic [31:0] c;
    int steps;
    c = 32'h0055_000F;
    steps = 0;
    for (int i = 0; i < 20; i++) begin
      apply(4'd1, 4'b0000, c, 32'h0000_6000, 16'hFFFA);
      steps++;
      c = count_o;
      if (!taken_o) break;
    end
    chk("R9 steps", 64'(steps), 64'd16);
    chk("R9 final count", {32'd0, c}, {32'd0, 32'h0055_FFFF});
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go_i = 1'b0; cond_i = '0; flags_i = '0;
    count_i = '0; pc_i = '0; disp_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_true_falls();
    t_false_branch();
    t_exit();
    t_hold();
    t_table();
    t_loop15();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule